// File: doc/BRIEF.md
# Cartridge Bus DMA Controller

This block is a register-programmed copy engine. It moves byte blocks between a main DRAM space and a cartridge address space. A processor writes the DRAM and cartridge start addresses through a 32-bit register bus. It then writes one of two length registers. The register that is written selects the direction and starts the copy at once.

Before the copy starts, the block normalises the addresses and the length. The length written is the byte count minus one. When the DRAM start address is not aligned to eight bytes, the length is shortened by the offset. When the copy ends, both address registers hold the address just past the block that was moved. The block then raises an interrupt request, which software clears through the status register.

Eight byte-wide scratch registers complete the register space. The engine drives two simple synchronous byte memory ports. A read strobe returns data on the next cycle, and a write strobe commits at the clock edge.

Top module: `cart_dma_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and no memory strobe is active.
- R2: A write to offset 0x0C starts a copy from the cartridge to DRAM. A write to offset 0x08 starts a copy from DRAM to the cartridge. Bytes are moved in ascending address order, and each byte takes a read cycle on the source port and then a write cycle on the destination port.
- R3: The byte count is the low 24 bits of the written value plus one. The DRAM start is the DRAM address register (offset 0x00) ANDed with 0x007FFFFE. The cartridge start is the cartridge address register (offset 0x04) with bit 0 cleared.
- R4: If the low three bits of the normalised DRAM start are nonzero, their value is subtracted from the byte count. If that value is equal to or larger than the count, no byte is moved.
- R5: When a copy ends, the address registers read their normalised starts plus the adjusted count. The length register of that direction reads the adjusted count. The other length register is unchanged.
- R6: The status register (offset 0x10) reads the busy flag in bit 0 and the pending interrupt in bit 3, and bits 1 and 2 read zero. Busy is set from the cycle after the start until the copy ends. `irq` equals the pending interrupt.
- R7: The end of a copy sets the pending interrupt and clears busy at the same clock edge.
- R8: A status write with bit 1 set clears the pending interrupt, unless a copy ends in the same cycle. A status write with bit 1 clear has no effect.
- R9: While busy, writes to the two length registers and the two address registers are ignored.
- R10: Eight scratch registers at offsets 0x14, 0x18 … 0x30 keep the low 8 bits of each write and read back zero-extended. Any other offset reads zero.
- R11: Outside a copy no memory strobe is active, and at most one of the four strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dram_addr | output | 23 | DRAM byte address |
| dram_re | output | 1 | DRAM read strobe, data on next cycle |
| dram_we | output | 1 | DRAM write strobe |
| dram_wdata | output | 8 | DRAM write data |
| dram_rdata | input | 8 | DRAM read data |
| cart_addr | output | 32 | Cartridge byte address |
| cart_re | output | 1 | Cartridge read strobe, data on next cycle |
| cart_we | output | 1 | Cartridge write strobe |
| cart_wdata | output | 8 | Cartridge write data |
| cart_rdata | input | 8 | Cartridge read data |
| irq | output | 1 | Interrupt request, high while pending |

## Verification
The hardest situation to reach from the ports is a register write that arrives while a copy is still running. This matters most for a second length write, which could restart the engine or change its direction in mid-copy. The stimulus starts a 16-byte copy. In the following cycles, while the status register still reports busy, it writes the other length register and then the DRAM address register. After the copy ends, the bench checks the length registers, the address registers and the memory region that the rejected copy would have written. Misalignment larger than the count is reached by pointing DRAM at offset 6 of an eight-byte word and requesting three bytes.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  typedef enum logic {
    DIR_TO_CART = 1'b0,
    DIR_TO_DRAM = 1'b1
  } dir_e;

  localparam logic [7:0] OFS_DRAM  = 8'h00;
  localparam logic [7:0] OFS_CART  = 8'h04;
  localparam logic [7:0] OFS_RDLEN = 8'h08;
  localparam logic [7:0] OFS_WRLEN = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_SCR0  = 8'h14;

  localparam int ST_BUSY = 0;
  localparam int ST_IRQ  = 3;
  localparam int ST_CLR  = 1;

  // DRAM start: keep the low aw address bits, drop bit 0
  function automatic logic [31:0] dram_norm(input logic [31:0] a, input int aw);
    return a & ((32'h1 << aw) - 32'h1) & ~32'h1;
  endfunction

  // Cartridge start: even address
  function automatic logic [31:0] cart_norm(input logic [31:0] a);
    return a & ~32'h1;
  endfunction

  // Byte count after misalignment trim; clamps at zero
  function automatic logic [31:0] len_adj(input logic [31:0] val, input logic [31:0] dstart,
                                         input int lw, input int ab);
    logic [31:0] raw;
    logic [31:0] mis;
    raw = (val & ((32'h1 << lw) - 32'h1)) + 32'h1;
    mis = dstart & ((32'h1 << ab) - 32'h1);
    return (mis >= raw) ? 32'h0 : raw - mis;
  endfunction

endpackage

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
#(
  parameter int DRAM_AW = 23,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ev,
  input  dir_e               start_dir,
  input  logic [DRAM_AW-1:0] dram_start,
  input  logic [31:0]        cart_start,
  input  logic [31:0]        len_new,
  output logic               busy,
  output logic               done_ev,
  output dir_e               xfer_dir,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic               dram_re,
  output logic               dram_we,
  output logic [BYTE_W-1:0]  dram_wdata,
  input  logic [BYTE_W-1:0]  dram_rdata,
  output logic [31:0]        cart_addr,
  output logic               cart_re,
  output logic               cart_we,
  output logic [BYTE_W-1:0]  cart_wdata,
  input  logic [BYTE_W-1:0]  cart_rdata
);

  logic               run_q;
  logic               phase_q;
  dir_e               dir_q;
  logic [31:0]        cnt_q;
  logic [DRAM_AW-1:0] dptr_q;
  logic [31:0]        cptr_q;
  logic               rd_phase;
  logic               wr_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      dir_q   <= DIR_TO_CART;
      cnt_q   <= '0;
      dptr_q  <= '0;
      cptr_q  <= '0;
    end else if (start_ev) begin
      run_q   <= 1'b1;
      phase_q <= 1'b0;
      dir_q   <= start_dir;
      cnt_q   <= len_new;
      dptr_q  <= dram_start;
      cptr_q  <= cart_start;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_q <= 1'b0;
      end else if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        cnt_q   <= cnt_q - 32'h1;
        dptr_q  <= dptr_q + 1'b1;
        cptr_q  <= cptr_q + 32'h1;
      end
    end
  end

  always_comb begin
    done_ev  = run_q && (cnt_q == '0);
    rd_phase = run_q && (cnt_q != '0) && !phase_q;
    wr_phase = run_q && (cnt_q != '0) && phase_q;
    dram_re  = rd_phase && (dir_q == DIR_TO_CART);
    cart_re  = rd_phase && (dir_q == DIR_TO_DRAM);
    dram_we  = wr_phase && (dir_q == DIR_TO_DRAM);
    cart_we  = wr_phase && (dir_q == DIR_TO_CART);
  end

  assign busy       = run_q;
  assign xfer_dir   = dir_q;
  assign dram_addr  = dptr_q;
  assign cart_addr  = cptr_q;
  assign dram_wdata = cart_rdata;
  assign cart_wdata = dram_rdata;

endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int AW    = 8,
  parameter int SCR_N = 8,
  parameter int SCR_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  logic          start_ev,
  input  dir_e          start_dir,
  input  logic [31:0]   dram_start,
  input  logic [31:0]   cart_start,
  input  logic [31:0]   len_new,
  input  logic          done_ev,
  output logic [31:0]   dram_q,
  output logic [31:0]   cart_q,
  output logic [31:0]   rd_len_q,
  output logic [31:0]   wr_len_q,
  output logic          irq_q
);

  logic [SCR_W-1:0] scr_q [SCR_N];
  logic             hit_dram;
  logic             hit_cart;
  logic             hit_stat;

  assign hit_dram = reg_wr && (reg_addr == AW'(OFS_DRAM));
  assign hit_cart = reg_wr && (reg_addr == AW'(OFS_CART));
  assign hit_stat = reg_wr && (reg_addr == AW'(OFS_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_q   <= '0;
      cart_q   <= '0;
      rd_len_q <= '0;
      wr_len_q <= '0;
    end else if (start_ev) begin
      dram_q <= dram_start + len_new;
      cart_q <= cart_start + len_new;
      if (start_dir == DIR_TO_CART) rd_len_q <= len_new;
      else                          wr_len_q <= len_new;
    end else if (!busy) begin
      if (hit_dram) dram_q <= reg_wdata;
      if (hit_cart) cart_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         irq_q <= 1'b0;
    else if (done_ev)                   irq_q <= 1'b1;
    else if (hit_stat && reg_wdata[ST_CLR]) irq_q <= 1'b0;
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        scr_q[g] <= '0;
      else if (reg_wr && (reg_addr == AW'(OFS_SCR0 + 4 * g)))
        scr_q[g] <= reg_wdata[SCR_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(OFS_DRAM))       reg_rdata = dram_q;
    else if (reg_addr == AW'(OFS_CART))  reg_rdata = cart_q;
    else if (reg_addr == AW'(OFS_RDLEN)) reg_rdata = rd_len_q;
    else if (reg_addr == AW'(OFS_WRLEN)) reg_rdata = wr_len_q;
    else if (reg_addr == AW'(OFS_STAT)) begin
      reg_rdata[ST_BUSY] = busy;
      reg_rdata[ST_IRQ]  = irq_q;
    end else begin
      for (int i = 0; i < SCR_N; i++) begin
        if (reg_addr == AW'(OFS_SCR0 + 4 * i)) reg_rdata[SCR_W-1:0] = scr_q[i];
      end
    end
  end

endmodule

// File: rtl/cart_dma_ctrl.sv
module cart_dma_ctrl
  import cdma_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DRAM_AW    = 23,
  parameter int LEN_W      = 24,
  parameter int ALIGN_BITS = 3,
  parameter int BYTE_W     = 8,
  parameter int SCR_N      = 8,
  parameter int SCR_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic               dram_re,
  output logic               dram_we,
  output logic [BYTE_W-1:0]  dram_wdata,
  input  logic [BYTE_W-1:0]  dram_rdata,
  output logic [31:0]        cart_addr,
  output logic               cart_re,
  output logic               cart_we,
  output logic [BYTE_W-1:0]  cart_wdata,
  input  logic [BYTE_W-1:0]  cart_rdata,
  output logic               irq
);

  logic        busy;
  logic        done_ev;
  logic        len_wr;
  logic        start_ev;
  logic        len_wr_busy;
  logic        stat_clr_ev;
  dir_e        start_dir;
  dir_e        xfer_dir;
  logic [31:0] dram_q;
  logic [31:0] cart_q;
  logic [31:0] rd_len_q;
  logic [31:0] wr_len_q;
  logic [31:0] dram_start;
  logic [31:0] cart_start;
  logic [31:0] len_new;

  assign len_wr      = reg_wr && ((reg_addr == AW'(OFS_RDLEN)) || (reg_addr == AW'(OFS_WRLEN)));
  assign start_ev    = len_wr && !busy;
  assign len_wr_busy = len_wr && busy;
  assign stat_clr_ev = reg_wr && (reg_addr == AW'(OFS_STAT)) && reg_wdata[ST_CLR];
  assign start_dir   = (reg_addr == AW'(OFS_WRLEN)) ? DIR_TO_DRAM : DIR_TO_CART;
  assign dram_start  = dram_norm(dram_q, DRAM_AW);
  assign cart_start  = cart_norm(cart_q);
  assign len_new     = len_adj(reg_wdata, dram_start, LEN_W, ALIGN_BITS);

  cdma_regs #(
    .AW    (AW),
    .SCR_N (SCR_N),
    .SCR_W (SCR_W)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .start_ev   (start_ev),
    .start_dir  (start_dir),
    .dram_start (dram_start),
    .cart_start (cart_start),
    .len_new    (len_new),
    .done_ev    (done_ev),
    .dram_q     (dram_q),
    .cart_q     (cart_q),
    .rd_len_q   (rd_len_q),
    .wr_len_q   (wr_len_q),
    .irq_q      (irq)
  );

  cdma_seq #(
    .DRAM_AW (DRAM_AW),
    .BYTE_W  (BYTE_W)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ev   (start_ev),
    .start_dir  (start_dir),
    .dram_start (dram_start[DRAM_AW-1:0]),
    .cart_start (cart_start),
    .len_new    (len_new),
    .busy       (busy),
    .done_ev    (done_ev),
    .xfer_dir   (xfer_dir),
    .dram_addr  (dram_addr),
    .dram_re    (dram_re),
    .dram_we    (dram_we),
    .dram_wdata (dram_wdata),
    .dram_rdata (dram_rdata),
    .cart_addr  (cart_addr),
    .cart_re    (cart_re),
    .cart_we    (cart_we),
    .cart_wdata (cart_wdata),
    .cart_rdata (cart_rdata)
  );

endmodule

// File: rtl/cdma_chk.sv
module cdma_chk
  import cdma_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start_ev,
  input logic        done_ev,
  input logic        busy,
  input logic        irq,
  input logic        stat_clr_ev,
  input logic        len_wr_busy,
  input dir_e        xfer_dir,
  input logic        dram_re,
  input logic        dram_we,
  input logic        cart_re,
  input logic        cart_we,
  input logic [31:0] rd_len_q,
  input logic [31:0] wr_len_q
);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy);

  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (irq && !busy));

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_ev && !done_ev) |=> !irq);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_clr_ev) |=> irq);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr_busy |=> ($stable(rd_len_q) && $stable(wr_len_q) && busy));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(dram_re || dram_we || cart_re || cart_we));

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dram_re, dram_we, cart_re, cart_we}));

  // R2
  direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_dir == DIR_TO_DRAM) |-> !(cart_we || dram_re));

endmodule

bind cart_dma_ctrl cdma_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_ev    (start_ev),
  .done_ev     (done_ev),
  .busy        (busy),
  .irq         (irq),
  .stat_clr_ev (stat_clr_ev),
  .len_wr_busy (len_wr_busy),
  .xfer_dir    (xfer_dir),
  .dram_re     (dram_re),
  .dram_we     (dram_we),
  .cart_re     (cart_re),
  .cart_we     (cart_we),
  .rd_len_q    (rd_len_q),
  .wr_len_q    (wr_len_q)
);

// File: tb/test_cart_dma_ctrl.sv
`timescale 1ns/1ps
module test_cart_dma_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [22:0] dram_addr;
  logic        dram_re, dram_we;
  logic [7:0]  dram_wdata;
  logic [7:0]  dram_rdata;
  logic [31:0] cart_addr;
  logic        cart_re, cart_we;
  logic [7:0]  cart_wdata;
  logic [7:0]  cart_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [7:0] dram_mem [256];
  logic [7:0] cart_mem [256];

  always #10 clk = ~clk;

  cart_dma_ctrl i_cart_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dram_addr(dram_addr), .dram_re(dram_re), .dram_we(dram_we),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .cart_addr(cart_addr), .cart_re(cart_re), .cart_we(cart_we),
    .cart_wdata(cart_wdata), .cart_rdata(cart_rdata), .irq(irq)
  );

  function automatic logic [7:0] dpat(input int i);
    return 8'(i) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] cpat(input int i);
    return 8'(i * 5 + 1);
  endfunction

  // Expected count, derived from R3/R4
  function automatic logic [31:0] exp_len(input logic [31:0] val, input logic [31:0] daddr);
    logic [31:0] start, cnt, off;
    start = daddr & 32'h007FFFFE;
    cnt   = {8'h0, val[23:0]} + 32'd1;
    off   = start % 8;
    if (off >= cnt) return 32'd0;
    return cnt - off;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        dram_mem[i] <= dpat(i);
        cart_mem[i] <= cpat(i);
      end
    end else begin
      if (dram_we) dram_mem[dram_addr[7:0]] <= dram_wdata;
      if (cart_we) cart_mem[cart_addr[7:0]] <= cart_wdata;
      if (dram_re) dram_rdata <= dram_mem[dram_addr[7:0]];
      if (cart_re) cart_rdata <= cart_mem[cart_addr[7:0]];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      rd(8'h10, s);
      if (!s[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a <= 8'h34; a += 4) begin
      rd(8'(a), v);
      chk($sformatf("R1 reg %0h after reset", a), v, 32'h0);
    end
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R11 strobes after reset", {28'h0, dram_re, dram_we, cart_re, cart_we}, 32'h0);
  endtask

  task automatic t_cart_to_dram();
    logic [31:0] v;
    logic [31:0] n;
    n = exp_len(32'h7, 32'h10);
    wr(8'h00, 32'h10);
    wr(8'h04, 32'h21);
    wr(8'h0C, 32'h7);
    rd(8'h10, v);
    chk("R6 status busy during copy", v, 32'h1);
    wait_idle();
    for (int k = 0; k < 8; k++)
      chk($sformatf("R2 dram byte %0d", k), {24'h0, dram_mem[8'h10 + k]}, {24'h0, cpat(8'h20 + k)});
    chk("R2 dram byte past end", {24'h0, dram_mem[8'h18]}, {24'h0, dpat(8'h18)});
    rd(8'h00, v); chk("R5 dram addr advanced", v, 32'h10 + n);
    rd(8'h04, v); chk("R3 R5 cart addr even and advanced", v, 32'h20 + n);
    rd(8'h0C, v); chk("R5 write length", v, n);
    rd(8'h08, v); chk("R5 other length untouched", v, 32'h0);
    rd(8'h10, v); chk("R6 R7 status after end", v, 32'h8);
    chk("R7 irq after end", {31'h0, irq}, 32'h1);
    wr(8'h10, 32'h1);
    chk("R8 clear without bit 1 ignored", {31'h0, irq}, 32'h1);
    wr(8'h10, 32'h2);
    chk("R8 clear with bit 1", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_dram_to_cart_misaligned();
    logic [31:0] v;
    logic [31:0] n;
    n = exp_len(32'hFF00_0005, 32'h8000_0043);
    chk("R3 R4 bench count", n, 32'd4);
    wr(8'h00, 32'h8000_0043);
    wr(8'h04, 32'h41);
    wr(8'h08, 32'hFF00_0005);
    wait_idle();
    for (int k = 0; k < 4; k++)
      chk($sformatf("R4 cart byte %0d", k), {24'h0, cart_mem[8'h40 + k]}, {24'h0, dpat(8'h42 + k)});
    chk("R4 cart byte past trimmed end", {24'h0, cart_mem[8'h44]}, {24'h0, cpat(8'h44)});
    rd(8'h00, v); chk("R3 R5 dram addr masked and advanced", v, 32'h42 + n);
    rd(8'h04, v); chk("R5 cart addr advanced", v, 32'h40 + n);
    rd(8'h08, v); chk("R5 read length", v, n);
    rd(8'h0C, v); chk("R5 write length kept", v, 32'd8);
    wr(8'h10, 32'h2);
  endtask

  task automatic t_busy_writes();
    logic [31:0] v;
    wr(8'h00, 32'h80);
    wr(8'h04, 32'h60);
    wr(8'h0C, 32'hF);
    wr(8'h08, 32'h3);
    wr(8'h00, 32'h1234);
    wr(8'h04, 32'h5678);
    rd(8'h10, v);
    chk("R9 still busy after ignored writes", v & 32'h1, 32'h1);
    wait_idle();
    rd(8'h0C, v); chk("R9 write length from first start", v, 32'd16);
    rd(8'h08, v); chk("R9 read length unchanged", v, 32'd4);
    rd(8'h00, v); chk("R9 dram addr ignores busy write", v, 32'h90);
    rd(8'h04, v); chk("R9 cart addr ignores busy write", v, 32'h70);
    chk("R9 no cart write from rejected start", {24'h0, cart_mem[8'h70]}, {24'h0, cpat(8'h70)});
    chk("R2 last byte of long copy", {24'h0, dram_mem[8'h8F]}, {24'h0, cpat(8'h6F)});
    wr(8'h10, 32'h2);
  endtask

  task automatic t_zero_count();
    logic [31:0] v;
    wr(8'h00, 32'h7);
    wr(8'h04, 32'h11);
    wr(8'h0C, 32'h2);
    wait_idle();
    rd(8'h0C, v); chk("R4 offset beyond count gives zero", v, 32'h0);
    rd(8'h00, v); chk("R4 dram addr not advanced", v, 32'h6);
    rd(8'h04, v); chk("R4 cart addr not advanced", v, 32'h10);
    chk("R4 no dram byte written", {24'h0, dram_mem[6]}, {24'h0, dpat(6)});
    chk("R7 irq on empty copy", {31'h0, irq}, 32'h1);
    wr(8'h10, 32'h2);
  endtask

  task automatic t_scratch();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr(8'(8'h14 + 4 * i), 32'hDEAD_BE00 + i * 17);
    for (int i = 0; i < 8; i++) begin
      rd(8'(8'h14 + 4 * i), v);
      chk($sformatf("R10 scratch %0d", i), v, (32'hDEAD_BE00 + i * 17) & 32'hFF);
    end
    rd(8'h34, v); chk("R10 unmapped offset", v, 32'h0);
    rd(8'h10, v); chk("R6 status io bits zero", v & 32'h6, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cart_to_dram();
    t_dram_to_cart_misaligned();
    t_busy_writes();
    t_zero_count();
    t_scratch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule